// File: doc/BRIEF.md
# Pruned Four-State Viterbi Decoder

This block recovers information bits from a hard-decision stream of a rate 1/3 convolutional code with constraint length 3. The code has four trellis states and generators 7, 7 and 5 (octal). Each accepted 3-bit symbol moves the trellis one step. Every state's new path metric comes from a two-way add-compare-select over its two predecessors, using the Hamming distance between the received symbol and the branch's expected symbol. After each step the metrics are normalized so that the best survivor sits at zero. Survivors farther above the best than a programmable threshold are then dropped, and so are all survivors beyond the `NMAX` lowest.

The block stores decision bits in a shift-register window. A combinational traceback starts from the best surviving state and walks back across `DEPTH` steps, which yields one decoded bit per accepted symbol once the window is full. The input and output both use a valid/ready handshake. The stream has no block boundaries, so symbols may arrive back to back for as long as the consumer keeps up.

Top module: `avd_decoder`

## Requirements
- R1: While reset is asserted, and in the cycle after, only state 0 is alive with metric 0. In that state `out_valid` is 0 and `in_ready` is 1.
- R2: Encoder state is {s1,s0}, where s1 is the previous information bit and s0 the one before it. For input u, the symbol is bit2 = u^s1^s0, bit1 = u^s1^s0, bit0 = u^s0, and the next state is {u,s1}.
- R3: Branch metric is the Hamming distance of received and expected symbol. Each state takes the cheaper of its two predecessors {s0,0} and {s0,1}. On a tie it takes the lower-index one. A dead predecessor is never chosen over a live one.
- R4: After every accepted symbol, at least one live state has metric 0.
- R5: After every accepted symbol, no live state has a metric above the threshold that was present at acceptance.
- R6: At no time are more than `NMAX` states alive. Among equal metrics, lower indices win the cap.
- R7: A dead state always holds the all-ones metric.
- R8: The first `out_valid` follows the `DEPTH`-th accepted symbol. After that, each accepted symbol yields exactly one decoded bit, in order.
- R9: An error-free coded stream (random, all-zero or all-one data) decodes to the original bits.
- R10: Single-bit errors spaced at least 25 symbols apart are corrected, including with threshold 0.
- R11: While `out_valid` is high and `out_ready` low, `in_ready` is low and `out_bit` holds.
- R12: With `out_ready` held high, `in_ready` stays high, so a symbol can be taken every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received symbol is present |
| in_ready | output | 1 | Decoder takes a symbol this cycle |
| in_sym | input | 3 | Hard-decision coded symbol |
| thresh | input | MW | Discard distance above the best metric |
| out_valid | output | 1 | Decoded bit is present |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded information bit |

## Verification
The bench drives several kinds of stream:
- Random error-free data checks the trellis wiring and the traceback alignment.
- Long all-zero and all-one runs exercise the states at the trellis edges, which random data visits unevenly.
- Isolated single-bit flips, first at a wide threshold and then at threshold 0, show that pruning keeps the correct path while discarding competitors.
- A phase with random input gaps and a stalling consumer separates stream timing from decoding.
- A mid-stream reset confirms that the fill latency starts again.

// File: rtl/avd_decoder.sv
module avd_decoder #(
  parameter int NMAX  = 2,
  parameter int DEPTH = 15,
  parameter int MW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_sym,
  input  logic [MW-1:0] thresh,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit
);
  localparam int NS = 4;
  localparam int CW = $clog2(DEPTH);
  localparam logic [MW-1:0] MMAX = '1;

  logic [NS-1:0][MW-1:0] met_q, cand, nmet;
  logic [NS-1:0]         valid_q, cval, keep, dec;
  logic [DEPTH-3:0][NS-1:0] mem_q;
  logic [DEPTH-1:0][1:0] st;
  logic [MW-1:0]         mmin;
  logic [1:0]            best;
  logic [CW-1:0]         cnt_q;
  logic                  acc;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  function automatic logic [1:0] bmet(logic [1:0] p, logic u, logic [2:0] s);
    logic [2:0] d;
    d = {u ^ p[1] ^ p[0], u ^ p[1] ^ p[0], u ^ p[0]} ^ s;
    return {1'b0, d[0]} + {1'b0, d[1]} + {1'b0, d[2]};
  endfunction

  function automatic logic [MW-1:0] sadd(logic [MW-1:0] a, logic [1:0] b);
    logic [MW:0] t;
    t = {1'b0, a} + {{(MW-1){1'b0}}, b};
    return t[MW] ? MMAX : t[MW-1:0];
  endfunction

  for (genvar s = 0; s < NS; s++) begin : g_acs
    localparam logic [1:0] P0 = 2'((s % 2) * 2);
    localparam logic [1:0] P1 = 2'((s % 2) * 2 + 1);
    localparam logic       U  = 1'(s / 2);
    logic [MW-1:0] c0, c1;
    logic          take1;
    assign c0    = sadd(met_q[P0], bmet(P0, U, in_sym));
    assign c1    = sadd(met_q[P1], bmet(P1, U, in_sym));
    assign take1 = valid_q[P1] && (!valid_q[P0] || c1 < c0);
    assign dec[s]  = take1;
    assign cval[s] = valid_q[P0] || valid_q[P1];
    assign cand[s] = take1 ? c1 : c0;
    assign nmet[s] = cand[s] - mmin;
  end

  always_comb begin
    mmin = MMAX;
    for (int s = 0; s < NS; s++)
      if (cval[s] && cand[s] < mmin) mmin = cand[s];
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      int r;
      r = 0;
      for (int j = 0; j < NS; j++)
        if (cval[j] && nmet[j] <= thresh &&
            (nmet[j] < nmet[s] || (nmet[j] == nmet[s] && j < s)))
          r++;
      keep[s] = cval[s] && nmet[s] <= thresh && r < NMAX;
    end
  end

  always_comb begin
    best = 2'd0;
    for (int s = NS - 1; s >= 0; s--)
      if (keep[s] && nmet[s] == '0) best = 2'(s);
  end

  always_comb begin
    st[0] = best;
    st[1] = {st[0][0], dec[st[0]]};
    for (int k = 2; k < DEPTH; k++)
      st[k] = {st[k-1][0], mem_q[k-2][st[k-1]]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 4'b0001;
      met_q     <= {MMAX, MMAX, MMAX, {MW{1'b0}}};
      mem_q     <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (acc) begin
        for (int s = 0; s < NS; s++) begin
          valid_q[s] <= keep[s];
          met_q[s]   <= keep[s] ? nmet[s] : MMAX;
        end
        mem_q[0] <= dec;
        for (int i = 1; i < DEPTH - 2; i++) mem_q[i] <= mem_q[i-1];
        if (cnt_q != CW'(DEPTH - 1)) cnt_q <= cnt_q + 1'b1;
      end
      if (acc && cnt_q == CW'(DEPTH - 1)) begin
        out_valid <= 1'b1;
        out_bit   <= st[DEPTH-1][1];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/avd_checker.sv
module avd_checker #(
  parameter int NMAX = 2,
  parameter int MW   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [3:0]          valid_q,
  input logic [3:0][MW-1:0]  met_q,
  input logic [MW-1:0]       thresh,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_bit
);
  logic          has_zero, dead_max;
  logic [MW-1:0] maxv;

  always_comb begin
    has_zero = 1'b0;
    dead_max = 1'b1;
    maxv     = '0;
    for (int s = 0; s < 4; s++) begin
      if (valid_q[s] && met_q[s] == '0) has_zero = 1'b1;
      if (!valid_q[s] && met_q[s] != '1) dead_max = 1'b0;
      if (valid_q[s] && met_q[s] > maxv) maxv = met_q[s];
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (valid_q == 4'b0001 && met_q[0] == '0 && !out_valid)); // R1
  AST_BEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    has_zero); // R4
  AST_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (maxv <= $past(thresh))); // R5
  AST_SURV_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) <= NMAX); // R6
  AST_DEAD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    dead_max); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R11
endmodule

bind avd_decoder avd_checker #(.NMAX(NMAX), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .met_q(met_q),
  .thresh(thresh), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
);

// File: tb/tb_avd_decoder.sv
module tb_avd_decoder;
  localparam int DEPTH = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_sym = '0;
  logic [7:0] thresh = 8'd6;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_bit;

  always #4 clk = ~clk;

  avd_decoder #(.NMAX(2), .DEPTH(DEPTH), .MW(8)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .thresh(thresh), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit)
  );

  int    checks = 0, errors = 0, n_acc = 0;
  bit    q[$];
  bit    seen_out = 0, bp = 0, cur_bit = 0, e1 = 0, e0 = 0;
  string tag = "R9";

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 encoder model: symbol {u^s1^s0, u^s1^s0, u^s0}, next state {u,s1}
  task automatic send(bit u, logic [2:0] flip, int gap);
    in_sym   = {u ^ e1 ^ e0, u ^ e1 ^ e0, u ^ e0} ^ flip;
    cur_bit  = u;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    e0 = e1;
    e1 = u;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    q.delete();
    n_acc = 0; seen_out = 0; e1 = 0; e0 = 0;
    rst_n = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && !seen_out) begin
        seen_out = 1;
        chk(n_acc == DEPTH, "R8", n_acc, DEPTH);
      end
      if (!bp) chk(in_ready == 1'b1, "R12", in_ready, 1);
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(1'b0, "R8", 1, 0);
        else begin
          bit exp_b;
          exp_b = q.pop_front();
          chk(out_bit == exp_b, tag, out_bit, exp_b);
        end
      end
      if (out_valid && !out_ready) chk(in_ready == 1'b0, "R11", in_ready, 0);
      if (in_valid && in_ready) begin
        q.push_back(cur_bit);
        n_acc++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp ? 1'($urandom % 2) : 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    do_reset();
    // R2 and R3 are exercised by every decoded-bit comparison below
    tag = "R9";
    for (int i = 0; i < 60; i++) send(1'($urandom % 2), 3'b000, 0);
    for (int i = 0; i < 30; i++) send(1'b0, 3'b000, 0);
    for (int i = 0; i < 30; i++) send(1'b1, 3'b000, 0);
    tag = "R10";
    for (int i = 0; i < 100; i++)
      send(1'($urandom % 2), (i % 25 == 12) ? 3'(1 << ($urandom % 3)) : 3'b000, 0);
    // threshold 0 leans hardest on R4 R5 R6 R7 pruning
    thresh = 8'd0;
    for (int i = 0; i < 75; i++)
      send(1'($urandom % 2), (i % 25 == 5) ? 3'(1 << ($urandom % 3)) : 3'b000, 0);
    thresh = 8'd6;
    tag = "R11";
    bp = 1;
    for (int i = 0; i < 80; i++) send(1'($urandom % 2), 3'b000, int'($urandom % 3));
    bp = 0;
    repeat (4) @(posedge clk);
    #1;
    do_reset();
    tag = "R8";
    for (int i = 0; i < 40; i++) send(1'($urandom % 2), 3'b000, 0);
    repeat (5) @(posedge clk);
    chk(seen_out == 1'b1, "R8", seen_out, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule